// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table held in memory. A miss request brings a virtual page number (VPN). The walker splits the VPN into an upper index and a lower index. It reads the first-level entry at the table root and uses that entry to locate the second-level table. It then reads the leaf entry there. The walker answers with either a complete translation, ready to be installed in the translation cache so that the access can be retried, or a page fault.

The walker has one memory read port with at most one read in flight. It handles one miss at a time and reports busy from acceptance until its response is taken. The first-level entry must be valid before the walk moves on. A first-level entry with its valid bit cleared ends the walk at once with a fault, and no second read is made.

Entry format, the same at both levels: bit 0 is valid, bit 1 is read permission, bit 2 is write permission, bit 3 is execute permission, bit 4 is dirty, bit 5 is referenced, bits 11:6 are reserved, and bits 31:12 hold a frame number. In a first-level entry that frame number is the page-aligned base of the second-level table.

Top module: `page_walk_engine`

## Requirements
- R1: After reset, busy is 0, req_ready is 1, resp_valid is 0 and mem_rd_valid is 0.
- R2: The first read of a walk uses address root_base + 4 * VPN[19:10].
- R3: The second read uses address {first-level entry bits 31:12, 12'b0} + 4 * VPN[9:0].
- R4: When both entries are valid, the response has resp_fault 0. resp_pfn carries leaf bits 31:12. resp_perm[0], resp_perm[1] and resp_perm[2] carry leaf bits 1, 2 and 3. resp_dirty carries leaf bit 4 and resp_ref carries leaf bit 5.
- R5: A leaf entry with bit 0 clear gives resp_fault 1, with resp_pfn, resp_perm, resp_dirty and resp_ref all 0.
- R6: A first-level entry with bit 0 clear gives a fault response after exactly one memory read, with all translation fields 0.
- R7: A request is accepted only when req_valid and req_ready are both high. From the next cycle until the response handshake, busy is 1 and req_ready is 0, and any req_valid during that time is ignored.
- R8: mem_rd_valid stays high with a stable mem_rd_addr until mem_rd_ready. No new read is issued while a read response is outstanding.
- R9: resp_valid and every response field hold steady until resp_ready is seen high.
- R10: The walk completes correctly for any number of wait cycles before mem_rd_ready and before mem_rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vpn | input | 20 | Virtual page number to resolve |
| root_base | input | 32 | Byte address of the first-level table |
| busy | output | 1 | A walk is in progress |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned table entry |
| resp_valid | output | 1 | Walk result available |
| resp_ready | input | 1 | Requester takes the result |
| resp_fault | output | 1 | Page fault |
| resp_pfn | output | 20 | Physical frame number |
| resp_perm | output | 3 | {execute, write, read} permissions |
| resp_dirty | output | 1 | Leaf dirty bit |
| resp_ref | output | 1 | Leaf referenced bit |

## Verification
The hardest case to reach from the ports is a walk cut short at the first level while the memory and the requester both stall, combined with requests that arrive while the walker is busy. The bench uses a memory model that it programs before each walk, so that chosen entries have their valid bit cleared. The model inserts set numbers of wait cycles before accepting a read and before returning data. In a separate stimulus thread the bench raises req_valid with a different VPN in the middle of a walk. It then counts the reads issued and compares the read addresses, so that an early exit or a stray second walk shows up.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    parameter int PA_W      = 32;
    parameter int PG_OFF_W  = 12;
    parameter int PFN_W     = PA_W - PG_OFF_W;
    parameter int PTE_BYTES = 4;
    localparam int PTE_SH   = $clog2(PTE_BYTES);

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic [5:0]       rsv;
        logic             refd;
        logic             dirty;
        logic             x;
        logic             w;
        logic             r;
        logic             valid;
    } pte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_RESP
    } walk_state_e;

    typedef struct packed {
        logic             fault;
        logic [PFN_W-1:0] pfn;
        logic [2:0]       perm;
        logic             dirty;
        logic             refd;
    } walk_result_t;

    function automatic logic [PA_W-1:0] table_base(input pte_t e);
        return {e.pfn, {PG_OFF_W{1'b0}}};
    endfunction

    function automatic walk_result_t leaf_to_result(input pte_t e);
        walk_result_t res;
        res = '0;
        if (e.valid) begin
            res.pfn   = e.pfn;
            res.perm  = {e.x, e.w, e.r};
            res.dirty = e.dirty;
            res.refd  = e.refd;
        end else begin
            res.fault = 1'b1;
        end
        return res;
    endfunction

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        mem_rd_ready,
    input  logic        mem_rsp_valid,
    input  logic        l1_entry_ok,
    input  logic        resp_ready,
    output logic        req_ready,
    output logic        accept,
    output logic        busy,
    output logic        mem_rd_valid,
    output logic        sel_l2,
    output logic        l1_take,
    output logic        leaf_take,
    output logic        resp_valid
);

    walk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (req_valid)     state_d = ST_L1_REQ;
            ST_L1_REQ:  if (mem_rd_ready)  state_d = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rsp_valid) state_d = l1_entry_ok ? ST_L2_REQ : ST_RESP;
            ST_L2_REQ:  if (mem_rd_ready)  state_d = ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rsp_valid) state_d = ST_RESP;
            ST_RESP:    if (resp_ready)    state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign req_ready    = (state_q == ST_IDLE);
    assign accept       = req_valid && req_ready;
    assign busy         = (state_q != ST_IDLE);
    assign mem_rd_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
    assign sel_l2       = (state_q == ST_L2_REQ);
    assign l1_take      = (state_q == ST_L1_WAIT) && mem_rsp_valid;
    assign leaf_take    = (state_q == ST_L2_WAIT) && mem_rsp_valid;
    assign resp_valid   = (state_q == ST_RESP);

    AST_ACCEPT_STARTS_READ: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy && mem_rd_valid && !sel_l2);  // R7
    AST_READ_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid);  // R8
    AST_L1_FAULT_SKIPS_L2: assert property (@(posedge clk) disable iff (rst)
        l1_take && !l1_entry_ok |=> resp_valid && !mem_rd_valid);  // R6
    AST_RESP_HELD: assert property (@(posedge clk) disable iff (rst)
        resp_valid && !resp_ready |=> resp_valid);  // R9

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int L1_W  = 10
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic [PA_W-1:0]  root_base,
    input  logic [PA_W-1:0]  l2_base,
    input  logic             sel_l2,
    output logic [PA_W-1:0]  rd_addr
);

    localparam int L2_W = VPN_W - L1_W;

    logic [L1_W-1:0] idx_hi;
    logic [L2_W-1:0] idx_lo;
    logic [PA_W-1:0] off_hi, off_lo;

    assign idx_hi = vpn[VPN_W-1:L2_W];
    assign idx_lo = vpn[L2_W-1:0];
    assign off_hi = PA_W'(idx_hi) << PTE_SH;
    assign off_lo = PA_W'(idx_lo) << PTE_SH;

    always_comb begin
        if (sel_l2) rd_addr = l2_base + off_lo;
        else        rd_addr = root_base + off_hi;
    end

endmodule

// File: rtl/ptw_walk_regs.sv
module ptw_walk_regs
    import ptw_pkg::*;
#(
    parameter int VPN_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [PA_W-1:0]  root_base,
    input  logic             l1_take,
    input  logic             leaf_take,
    input  logic [PA_W-1:0]  rsp_data,
    output logic [VPN_W-1:0] vpn_q,
    output logic [PA_W-1:0]  root_q,
    output logic [PA_W-1:0]  l2_base_q,
    output walk_result_t     result_q,
    output logic             l1_entry_ok
);

    pte_t entry;
    assign entry       = pte_t'(rsp_data);
    assign l1_entry_ok = entry.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            vpn_q     <= '0;
            root_q    <= '0;
            l2_base_q <= '0;
            result_q  <= '0;
        end else begin
            if (accept) begin
                vpn_q    <= req_vpn;
                root_q   <= root_base;
                result_q <= '0;
            end
            if (l1_take) begin
                l2_base_q <= table_base(entry);
                if (!entry.valid) begin
                    result_q       <= '0;
                    result_q.fault <= 1'b1;
                end
            end
            if (leaf_take) result_q <= leaf_to_result(entry);
        end
    end

    AST_FAULT_CLEARS_FIELDS: assert property (@(posedge clk) disable iff (rst)
        result_q.fault |-> (result_q.pfn == '0) && (result_q.perm == '0)
                           && !result_q.dirty && !result_q.refd);  // R5

endmodule

// File: rtl/page_walk_engine.sv
module page_walk_engine
    import ptw_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int L1_W  = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VPN_W-1:0]       req_vpn,
    input  logic [ptw_pkg::PA_W-1:0]  root_base,
    output logic                   busy,
    output logic                   mem_rd_valid,
    input  logic                   mem_rd_ready,
    output logic [ptw_pkg::PA_W-1:0]  mem_rd_addr,
    input  logic                   mem_rsp_valid,
    input  logic [ptw_pkg::PA_W-1:0]  mem_rsp_data,
    output logic                   resp_valid,
    input  logic                   resp_ready,
    output logic                   resp_fault,
    output logic [ptw_pkg::PFN_W-1:0] resp_pfn,
    output logic [2:0]             resp_perm,
    output logic                   resp_dirty,
    output logic                   resp_ref
);

    logic             accept, sel_l2, l1_take, leaf_take, l1_entry_ok;
    logic [VPN_W-1:0] vpn_q;
    logic [PA_W-1:0]  root_q, l2_base_q;
    walk_result_t     result_q;

    ptw_ctrl u_ctrl (
        .clk, .rst, .req_valid, .mem_rd_ready, .mem_rsp_valid,
        .l1_entry_ok, .resp_ready, .req_ready, .accept, .busy,
        .mem_rd_valid, .sel_l2, .l1_take, .leaf_take, .resp_valid
    );

    ptw_walk_regs #(.VPN_W(VPN_W)) u_regs (
        .clk, .rst, .accept, .req_vpn, .root_base, .l1_take, .leaf_take,
        .rsp_data(mem_rsp_data), .vpn_q, .root_q, .l2_base_q, .result_q,
        .l1_entry_ok
    );

    ptw_addr_gen #(.VPN_W(VPN_W), .L1_W(L1_W)) u_addr (
        .vpn(vpn_q), .root_base(root_q), .l2_base(l2_base_q),
        .sel_l2, .rd_addr(mem_rd_addr)
    );

    assign resp_fault = result_q.fault;
    assign resp_pfn   = result_q.pfn;
    assign resp_perm  = result_q.perm;
    assign resp_dirty = result_q.dirty;
    assign resp_ref   = result_q.refd;

    AST_READ_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid && !mem_rd_ready |=> $stable(mem_rd_addr));  // R8
    AST_RESP_FIELDS_STABLE: assert property (@(posedge clk) disable iff (rst)
        resp_valid && !resp_ready |=> $stable(resp_fault) && $stable(resp_pfn)
                                      && $stable(resp_perm) && $stable(resp_dirty)
                                      && $stable(resp_ref));  // R9

endmodule

// File: tb/page_walk_engine_tb_top.sv
module page_walk_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, busy;
    logic [19:0] req_vpn;
    logic [31:0] root_base;
    logic        mem_rd_valid, mem_rd_ready;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        resp_valid, resp_ready, resp_fault, resp_dirty, resp_ref;
    logic [19:0] resp_pfn;
    logic [2:0]  resp_perm;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [logic [31:0]];
    int          rdy_dly = 0;
    int          rsp_dly = 0;
    int          rd_count = 0;
    int          overlap_err = 0;
    logic [31:0] rd_log [0:3];

    always #5 clk = ~clk;

    page_walk_engine dut_i (
        .clk, .rst, .req_valid, .req_ready, .req_vpn, .root_base, .busy,
        .mem_rd_valid, .mem_rd_ready, .mem_rd_addr, .mem_rsp_valid,
        .mem_rsp_data, .resp_valid, .resp_ready, .resp_fault, .resp_pfn,
        .resp_perm, .resp_dirty, .resp_ref
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory model: single read in flight, programmable stalls
    initial begin
        logic [31:0] a;
        mem_rd_ready  = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (!rst && mem_rd_valid) begin
                for (int i = 0; i < rdy_dly; i++) @(negedge clk);
                mem_rd_ready = 1'b1;
                a = mem_rd_addr;
                @(negedge clk);
                mem_rd_ready = 1'b0;
                if (rd_count < 4) rd_log[rd_count] = a;
                rd_count++;
                for (int i = 0; i < rsp_dly; i++) begin
                    if (mem_rd_valid) overlap_err++;
                    @(negedge clk);
                end
                if (mem_rd_valid) overlap_err++;
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem.exists(a) ? mem[a] : 32'h0;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = '0;
            end
        end
    end

    task automatic do_walk(input string tag, input logic [19:0] vpn,
                           input logic [31:0] root, input bit l1_ok,
                           input logic [19:0] l2pfn, input bit leaf_ok,
                           input logic [19:0] leaf_pfn, input logic [4:0] flags,
                           input int rdly, input int sdly, input bit inject);
        logic [31:0] l1a, l2a, exp_pfn;
        logic [2:0]  exp_perm;
        logic [24:0] snap;
        bit          exp_fault;
        int          exp_reads, waited;
        mem.delete();
        rdy_dly = rdly; rsp_dly = sdly; rd_count = 0; overlap_err = 0;
        l1a = root + {20'd0, vpn[19:10], 2'b00};
        l2a = {l2pfn, 12'h000} + {20'd0, vpn[9:0], 2'b00};
        mem[l1a] = {l2pfn, 6'd0, 5'd0, l1_ok};
        if (l1_ok) mem[l2a] = {leaf_pfn, 6'd0, flags, leaf_ok};
        exp_fault = !l1_ok || !leaf_ok;
        exp_reads = l1_ok ? 2 : 1;
        exp_pfn   = exp_fault ? 32'h0 : {12'h0, leaf_pfn};
        exp_perm  = exp_fault ? 3'b000 : flags[2:0];

        @(negedge clk);
        check("R7", {tag, " ready before accept"}, {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_vpn = vpn; root_base = root;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7", {tag, " busy after accept"}, {31'd0, busy}, 32'd1);
        check("R7", {tag, " ready low while busy"}, {31'd0, req_ready}, 32'd0);
        fork
            begin
                waited = 0;
                while (!resp_valid && waited < 500) begin
                    @(negedge clk);
                    waited++;
                end
            end
            begin
                if (inject) begin
                    @(negedge clk);
                    req_valid = 1'b1; req_vpn = ~vpn; root_base = root + 32'h40;
                    repeat (3) @(negedge clk);
                    req_valid = 1'b0;
                end
            end
        join
        check("R10", {tag, " response arrived"}, {31'd0, resp_valid}, 32'd1);
        check(exp_fault ? (l1_ok ? "R5" : "R6") : "R4", {tag, " fault"},
              {31'd0, resp_fault}, {31'd0, exp_fault});
        check(exp_fault ? "R5" : "R4", {tag, " pfn"}, {12'h0, resp_pfn}, exp_pfn);
        check(exp_fault ? "R5" : "R4", {tag, " perm"}, {29'd0, resp_perm}, {29'd0, exp_perm});
        check(exp_fault ? "R5" : "R4", {tag, " dirty"}, {31'd0, resp_dirty},
              {31'd0, !exp_fault && flags[3]});
        check(exp_fault ? "R5" : "R4", {tag, " ref"}, {31'd0, resp_ref},
              {31'd0, !exp_fault && flags[4]});
        check(l1_ok ? "R8" : "R6", {tag, " read count"}, rd_count, exp_reads);
        check("R2", {tag, " level-1 address"}, rd_log[0], l1a);
        if (l1_ok) check("R3", {tag, " level-2 address"}, rd_log[1], l2a);
        check("R8", {tag, " no overlapping read"}, overlap_err, 0);
        check("R7", {tag, " busy during response"}, {31'd0, busy}, 32'd1);
        snap = {resp_fault, resp_pfn, resp_perm, resp_dirty};
        repeat (2) @(negedge clk);
        check("R9", {tag, " response held"}, {31'd0, resp_valid}, 32'd1);
        check("R9", {tag, " fields held"}, {7'd0, resp_fault, resp_pfn, resp_perm, resp_dirty},
              {7'd0, snap});
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
        check("R7", {tag, " idle after handshake"}, {30'd0, busy, resp_valid}, 32'd0);
        check("R7", {tag, " no extra walk"}, rd_count, exp_reads);
    endtask

    task automatic test_reset();
        check("R1", "busy after reset", {31'd0, busy}, 32'd0);
        check("R1", "req_ready after reset", {31'd0, req_ready}, 32'd1);
        check("R1", "resp_valid after reset", {31'd0, resp_valid}, 32'd0);
        check("R1", "mem_rd_valid after reset", {31'd0, mem_rd_valid}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_vpn = '0; root_base = '0; resp_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        do_walk("basic",   20'h12345, 32'h0010_0000, 1'b1, 20'hABCDE, 1'b1, 20'h5A5A5, 5'b01011, 0, 0, 1'b0);
        do_walk("stalled", 20'h3FC01, 32'h0800_0000, 1'b1, 20'h00042, 1'b1, 20'hF00D1, 5'b10101, 3, 5, 1'b1);
        do_walk("leafbad", 20'h00400, 32'h0000_1000, 1'b1, 20'h77777, 1'b0, 20'h12345, 5'b11111, 1, 2, 1'b0);
        do_walk("l1bad",   20'h8000F, 32'h0020_0000, 1'b0, 20'h33333, 1'b1, 20'h44444, 5'b11111, 2, 4, 1'b1);
        do_walk("allones", 20'hFFFFF, 32'h0003_0000, 1'b1, 20'hFFFFF, 1'b1, 20'hFFFFF, 5'b11100, 0, 1, 1'b0);
        do_walk("zero",    20'h00000, 32'h0000_0000, 1'b1, 20'h00001, 1'b1, 20'h00000, 5'b00001, 4, 0, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule